// File: doc/BRIEF.md
# Fractional T1/E1 Time-Slot Cell Port

This block sits between a cell transmit/receive pipeline and one T1 or E1 framer port. In the transmit direction it accepts cell bytes through a valid/ready handshake and puts them, one bit per framer clock edge, onto the serial line. In the receive direction it takes serial bits from the framer and delivers whole bytes with a one-cycle valid pulse. Only the time slots enabled in a 32-bit slot mask carry cell bits. The T1 framing bit is always skipped. The byte boundary runs on across skipped positions, so cell bytes need not line up with time slots. Cell delineation is left to the stage downstream.

The framer clock, the frame pulse and the data are oversampled in the system clock domain. Either clock edge can be chosen as the active one, separately for each direction. The framer can mark overhead in two ways. In frame-pulse mode it gives a pulse that flags the first bit of each frame, and the block tracks frame position itself. In gapped-clock mode it suppresses clock edges during overhead and unused slots, so every edge carries payload. A diagnostic loopback feeds the transmit serial stream back into the receive path, timed by an internal tick every 8 system clocks.

Top module: `tdm_cell_port`

## Requirements
- R1: While rst_ni is low, tx_data_o is 1, tx_ready_o is 0 and rx_valid_o is 0.
- R2: T1 frame-pulse mode (cfg_e1_i=0, cfg_gapped_i=0): a frame has 193 bit positions. Position 0 is the framing bit. Positions 1..192 are slots 0..23, eight bits each. On receive, the framing bit and the bits of slots whose mask bit (cfg_slot_en_i[n] for slot n) is 0 are ignored. The remaining bits are packed most significant bit first into bytes, and byte alignment carries on across ignored bits.
- R3: On transmit, every payload position carries the next bit of the current byte, most significant bit first. Every non-payload position (framing bit or disabled slot) is driven as 1.
- R4: E1 frame-pulse mode (cfg_e1_i=1): a frame is 32 slots of eight bits, 256 positions, and slot n is enabled by mask bit n. With all 32 bits set, every position carries payload (clear channel).
- R5: In frame-pulse mode, a frame pulse sampled at an active edge marks that bit as frame position 0. It realigns slot tracking even in the middle of a frame.
- R6: Gapped-clock mode (cfg_gapped_i=1): every active clock edge carries one payload bit in both directions. The mask and the frame pulse have no effect.
- R7: cfg_tx_fall_i / cfg_rx_fall_i select the active framer clock edge per direction: 0 selects the rising edge and 1 the falling edge. Transmit data changes after the active edge and receive data is sampled at it.
- R8: tx_ready_o pulses for one cycle when a new byte is needed at a payload position. If tx_valid_i is high in that cycle, tx_byte_i is taken. Otherwise the byte position is filled with 8'hFF.
- R9: With cfg_loop_i=1, the transmit serial output feeds the receive path and both directions advance on an internal tick every 8 system clocks. Framer clocks, frame pulses and rx_data_i have no effect. Bytes are received in the order they were sent.
- R10: rx_valid_o is a single-cycle pulse per received byte, and rx_byte_o is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_e1_i | input | 1 | 1: E1 framing, 0: T1 framing |
| cfg_gapped_i | input | 1 | 1: gapped-clock mode, 0: frame-pulse mode |
| cfg_loop_i | input | 1 | Diagnostic loopback enable |
| cfg_tx_fall_i | input | 1 | Transmit active edge, 1 = falling |
| cfg_rx_fall_i | input | 1 | Receive active edge, 1 = falling |
| cfg_slot_en_i | input | 32 | Per-slot payload enable |
| tx_byte_i | input | 8 | Next cell byte to send |
| tx_valid_i | input | 1 | tx_byte_i is available |
| tx_ready_o | output | 1 | Byte taken this cycle |
| tx_lclk_i | input | 1 | Transmit framer clock |
| tx_fp_i | input | 1 | Transmit frame pulse |
| tx_data_o | output | 1 | Transmit serial data |
| rx_lclk_i | input | 1 | Receive framer clock |
| rx_fp_i | input | 1 | Receive frame pulse |
| rx_data_i | input | 1 | Receive serial data |
| rx_byte_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |

## Verification
A wrong slot position or an off-by-one in the frame counter shows up within one frame. On receive it corrupts the byte stream from the first misplaced bit, and on transmit a 0 appears at a position that must stay 1. A byte counter that slips turns every later byte into a rotated copy, so the first miscompare arrives no more than eight payload bits after the fault. A loopback tick skew shifts the returned bytes by one bit and fails the first byte. A stuck handshake starves the receive stream, which the per-phase byte counts catch.

// File: rtl/tdm_cell_pkg.sv
package tdm_cell_pkg;
  localparam int unsigned SLOT_W     = 8;
  localparam int unsigned T1_SLOTS   = 24;
  localparam int unsigned E1_SLOTS   = 32;
  localparam int unsigned MAX_SLOTS  = E1_SLOTS;
  localparam int unsigned SLOT_IDX_W = $clog2(MAX_SLOTS);
  localparam int unsigned BIT_IDX_W  = $clog2(SLOT_W);

  typedef struct packed {
    logic                  fbit;
    logic [SLOT_IDX_W-1:0] slot;
    logic [BIT_IDX_W-1:0]  bidx;
  } frame_pos_t;

  function automatic frame_pos_t frame_start(input logic e1);
    frame_pos_t p;
    p.fbit = ~e1;
    p.slot = '0;
    p.bidx = '0;
    return p;
  endfunction

  function automatic frame_pos_t frame_next(input frame_pos_t p, input logic e1);
    frame_pos_t n;
    logic [SLOT_IDX_W-1:0] last;
    last = e1 ? SLOT_IDX_W'(E1_SLOTS - 1) : SLOT_IDX_W'(T1_SLOTS - 1);
    n = p;
    if (p.fbit) begin
      n.fbit = 1'b0;
      n.slot = '0;
      n.bidx = '0;
    end else if (p.bidx == BIT_IDX_W'(SLOT_W - 1)) begin
      if (p.slot >= last) begin
        n = frame_start(e1);
      end else begin
        n.slot = p.slot + 1'b1;
        n.bidx = '0;
      end
    end else begin
      n.bidx = p.bidx + 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/tdm_edge_tick.sv
module tdm_edge_tick #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SIG_W       = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lclk_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             fall_i,
  output logic             tick_o,
  output logic [SIG_W-1:0] sig_o
);
  localparam int unsigned LW = SIG_W + 1;

  logic [LW-1:0] stage_q [SYNC_STAGES];
  logic          lclk_prev_q;
  logic          lclk_cur;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= {lclk_i, sig_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign lclk_cur = stage_q[SYNC_STAGES-1][LW-1];
  assign sig_o    = stage_q[SYNC_STAGES-1][SIG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lclk_prev_q <= 1'b0;
    else         lclk_prev_q <= lclk_cur;
  end

  assign tick_o = fall_i ? (lclk_prev_q & ~lclk_cur) : (~lclk_prev_q & lclk_cur);
endmodule

// File: rtl/tdm_loop_tick.sv
module tdm_loop_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!en_i)                      cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))      cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

  AST_LOOP_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R9
endmodule

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
  import tdm_cell_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 fp_i,
  input  logic                 e1_i,
  input  logic                 gapped_i,
  input  logic [MAX_SLOTS-1:0] slot_en_i,
  output logic                 payload_o
);
  frame_pos_t pos_q, pos_cur;
  logic       fresh_q;

  always_comb begin
    if ((fp_i && !gapped_i) || fresh_q) pos_cur = frame_start(e1_i);
    else                                pos_cur = pos_q;
  end

  assign payload_o = gapped_i | (~pos_cur.fbit & slot_en_i[pos_cur.slot]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      fresh_q <= 1'b1;
    end else if (tick_i) begin
      pos_q   <= frame_next(pos_cur, e1_i);
      fresh_q <= 1'b0;
    end
  end

  AST_E1_FP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fp_i && !gapped_i && e1_i) |=>
      (!pos_q.fbit && pos_q.slot == '0 && pos_q.bidx == BIT_IDX_W'(1))); // R5
  AST_T1_FP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fp_i && !gapped_i && !e1_i) |=>
      (!pos_q.fbit && pos_q.slot == '0 && pos_q.bidx == '0)); // R2
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          payload_i,
  input  logic [DW-1:0] byte_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          data_o
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW-2:0] sh_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] word;

  assign ready_o = tick_i && payload_i && (left_q == '0);
  assign word    = valid_i ? byte_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      data_o <= 1'b1;
    end else if (tick_i) begin
      if (!payload_i) begin
        data_o <= 1'b1;
      end else if (left_q == '0) begin
        data_o <= word[DW-1];
        sh_q   <= word[DW-2:0];
        left_q <= CW'(DW - 1);
      end else begin
        data_o <= sh_q[DW-2];
        sh_q   <= {sh_q[DW-3:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  AST_TX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (left_q == CW'(DW - 1))); // R8
  AST_TX_IDLE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !payload_i) |=> data_o); // R3
endmodule

// File: rtl/tdm_rx_deserializer.sv
module tdm_rx_deserializer #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          payload_i,
  input  logic          bit_i,
  output logic [DW-1:0] byte_o,
  output logic          valid_o
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW-2:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i && payload_i) begin
        if (cnt_q == CW'(DW - 1)) begin
          byte_o  <= {sh_q, bit_i};
          valid_o <= 1'b1;
          cnt_q   <= '0;
        end else begin
          sh_q  <= {sh_q[DW-3:0], bit_i};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_RX_FROM_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i && payload_i)); // R2
  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R10
endmodule

// File: rtl/tdm_cell_port.sv
module tdm_cell_port
  import tdm_cell_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOOP_DIV    = 8,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_e1_i,
  input  logic                 cfg_gapped_i,
  input  logic                 cfg_loop_i,
  input  logic                 cfg_tx_fall_i,
  input  logic                 cfg_rx_fall_i,
  input  logic [MAX_SLOTS-1:0] cfg_slot_en_i,
  input  logic [BYTE_W-1:0]    tx_byte_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  input  logic                 tx_lclk_i,
  input  logic                 tx_fp_i,
  output logic                 tx_data_o,
  input  logic                 rx_lclk_i,
  input  logic                 rx_fp_i,
  input  logic                 rx_data_i,
  output logic [BYTE_W-1:0]    rx_byte_o,
  output logic                 rx_valid_o
);
  logic       tx_line_tick, tx_line_fp;
  logic       rx_line_tick;
  logic [1:0] rx_line_sig;
  logic       loop_tick, loop_tick_d_q;
  logic       tx_tick, tx_fp, tx_payload;
  logic       rx_tick, rx_fp, rx_bit, rx_payload;

  tdm_edge_tick #(.SYNC_STAGES(SYNC_STAGES), .SIG_W(1)) i_tx_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .lclk_i (tx_lclk_i), .sig_i (tx_fp_i),
    .fall_i (cfg_tx_fall_i), .tick_o (tx_line_tick), .sig_o (tx_line_fp)
  );

  tdm_edge_tick #(.SYNC_STAGES(SYNC_STAGES), .SIG_W(2)) i_rx_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .lclk_i (rx_lclk_i), .sig_i ({rx_fp_i, rx_data_i}),
    .fall_i (cfg_rx_fall_i), .tick_o (rx_line_tick), .sig_o (rx_line_sig)
  );

  tdm_loop_tick #(.DIV(LOOP_DIV)) i_loop_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (cfg_loop_i), .tick_o (loop_tick)
  );

  // receive side of loopback lags one cycle so it samples the freshly driven bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loop_tick_d_q <= 1'b0;
    else         loop_tick_d_q <= loop_tick;
  end

  assign tx_tick = cfg_loop_i ? loop_tick     : tx_line_tick;
  assign tx_fp   = cfg_loop_i ? 1'b0          : tx_line_fp;
  assign rx_tick = cfg_loop_i ? loop_tick_d_q : rx_line_tick;
  assign rx_fp   = cfg_loop_i ? 1'b0          : rx_line_sig[1];
  assign rx_bit  = cfg_loop_i ? tx_data_o     : rx_line_sig[0];

  tdm_slot_tracker i_tx_track (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tx_tick), .fp_i (tx_fp),
    .e1_i (cfg_e1_i), .gapped_i (cfg_gapped_i), .slot_en_i (cfg_slot_en_i),
    .payload_o (tx_payload)
  );

  tdm_slot_tracker i_rx_track (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (rx_tick), .fp_i (rx_fp),
    .e1_i (cfg_e1_i), .gapped_i (cfg_gapped_i), .slot_en_i (cfg_slot_en_i),
    .payload_o (rx_payload)
  );

  tdm_tx_serializer #(.DW(BYTE_W)) i_tx_ser (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tx_tick), .payload_i (tx_payload),
    .byte_i (tx_byte_i), .valid_i (tx_valid_i), .ready_o (tx_ready_o), .data_o (tx_data_o)
  );

  tdm_rx_deserializer #(.DW(BYTE_W)) i_rx_deser (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (rx_tick), .payload_i (rx_payload),
    .bit_i (rx_bit), .byte_o (rx_byte_o), .valid_o (rx_valid_o)
  );

  AST_READY_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (cfg_loop_i ? loop_tick : tx_line_tick)); // R8
endmodule

// File: tb/test_tdm_cell_port.sv
module test_tdm_cell_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_e1_i = 1'b0, cfg_gapped_i = 1'b0, cfg_loop_i = 1'b0;
  logic        cfg_tx_fall_i = 1'b0, cfg_rx_fall_i = 1'b0;
  logic [31:0] cfg_slot_en_i = '0;
  logic [7:0]  tx_byte_i = 8'h21;
  logic        tx_valid_i = 1'b1;
  logic        tx_ready_o;
  logic        tx_lclk_i = 1'b0, tx_fp_i = 1'b0;
  logic        tx_data_o;
  logic        rx_lclk_i = 1'b0, rx_fp_i = 1'b0, rx_data_i = 1'b0;
  logic [7:0]  rx_byte_o;
  logic        rx_valid_o;

  always #4 clk_i = ~clk_i;

  tdm_cell_port i_tdm_cell_port (
    .clk_i, .rst_ni, .cfg_e1_i, .cfg_gapped_i, .cfg_loop_i, .cfg_tx_fall_i,
    .cfg_rx_fall_i, .cfg_slot_en_i, .tx_byte_i, .tx_valid_i, .tx_ready_o,
    .tx_lclk_i, .tx_fp_i, .tx_data_o, .rx_lclk_i, .rx_fp_i, .rx_data_i,
    .rx_byte_o, .rx_valid_o
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  bit    loop_mode = 0;
  string rx_tag = "R2", tx_tag = "R3";
  int    rx_count = 0;
  bit    prev_rxv = 0;
  logic [7:0] src_byte = 8'h5A;
  int    src_cnt = 0;
  logic [7:0] tx_acc = '0;
  int    tx_n = 0;
  bit    have_prev = 0, prev_pl = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  // driver side of the scoreboard: record each byte the design takes
  initial forever begin
    @(negedge clk_i);
    if (rst_ni && tx_ready_o) begin
      logic [7:0] b;
      b = tx_valid_i ? tx_byte_i : 8'hFF;
      if (loop_mode) exp_rx.push_back(b);
      else           exp_tx.push_back(b);
      @(posedge clk_i);
      #1 tx_byte_i = tx_byte_i * 8'd13 + 8'd7;
    end
  end

  // monitor: compare received bytes in order (R10 pulse width too)
  initial forever begin
    @(negedge clk_i);
    if (rst_ni && rx_valid_o) begin
      check(!prev_rxv, "R10", "rx_valid_o wider than one cycle", 1, 0);
      rx_count++;
      if (exp_rx.size() == 0) check(1'b0, rx_tag, "unexpected rx byte", rx_byte_o, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(rx_byte_o == e, rx_tag, "rx byte", rx_byte_o, e);
      end
    end
    prev_rxv = rst_ni && rx_valid_o;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    exp_tx.delete(); exp_rx.delete();
    rx_count = 0; src_cnt = 0; tx_n = 0; have_prev = 0; prev_pl = 0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic rx_next_bit(output logic b);
    if (src_cnt == 0) begin
      src_byte = src_byte * 8'd29 + 8'd101;
      exp_rx.push_back(src_byte);
    end
    b = src_byte[7 - src_cnt];
    src_cnt = (src_cnt == 7) ? 0 : src_cnt + 1;
  endtask

  task automatic tx_sample(input bit pl);
    logic b;
    b = tx_data_o;
    if (pl) begin
      tx_acc = {tx_acc[6:0], b};
      tx_n++;
      if (tx_n == 8) begin
        tx_n = 0;
        if (exp_tx.size() == 0) check(1'b0, tx_tag, "tx byte with none taken", tx_acc, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          check(tx_acc == e, tx_tag, "tx byte", tx_acc, e);
        end
      end
    end else begin
      check(b == 1'b1, "R3", "non-payload tx bit", b, 1);
    end
  endtask

  // one line bit: inactive half with data setup, then active edge (R7)
  task automatic line_bit(input logic fp, input logic d, input bit pl, input logic fall);
    @(negedge clk_i);
    tx_lclk_i = fall; rx_lclk_i = fall;
    tx_fp_i = fp; rx_fp_i = fp; rx_data_i = d;
    repeat (7) @(negedge clk_i);
    if (have_prev) tx_sample(prev_pl);
    tx_lclk_i = ~fall; rx_lclk_i = ~fall;
    repeat (8) @(negedge clk_i);
    have_prev = 1; prev_pl = pl;
  endtask

  function automatic bit model_payload(input int pos, input bit e1, input logic [31:0] m);
    if (e1) return m[pos >> 3];
    if (pos == 0) return 1'b0;
    return m[(pos - 1) >> 3];
  endfunction

  task automatic run_frames(input bit e1, input logic [31:0] m, input logic fall,
                            input int nbits, input int realign_at, input int min_bytes,
                            input string tag);
    int pos, len;
    cfg_e1_i = e1; cfg_gapped_i = 0; cfg_loop_i = 0; loop_mode = 0;
    cfg_tx_fall_i = fall; cfg_rx_fall_i = fall; cfg_slot_en_i = m;
    tx_lclk_i = fall; rx_lclk_i = fall;
    rx_tag = tag; tx_tag = tag;
    do_reset();
    len = e1 ? 256 : 193;
    pos = 0;
    for (int i = 0; i < nbits; i++) begin
      logic d;
      bit pl;
      if (i == realign_at) begin
        pos = 0; rx_tag = "R5"; tx_tag = "R5";
      end
      pl = model_payload(pos, e1, m);
      if (pl) rx_next_bit(d);
      else    d = i[0];
      line_bit(pos == 0, d, pl, fall);
      pos = (pos + 1) % len;
    end
    repeat (16) @(negedge clk_i);
    check(rx_count >= min_bytes, tag, "rx byte count", rx_count, min_bytes);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(tx_data_o == 1'b1, "R1", "tx_data_o in reset", tx_data_o, 1);
    check(tx_ready_o == 1'b0, "R1", "tx_ready_o in reset", tx_ready_o, 0);
    check(rx_valid_o == 1'b0, "R1", "rx_valid_o in reset", rx_valid_o, 0);

    // R2 R3 R5 R7: T1 fractional, rising edge, early frame pulse at bit 300
    run_frames(1'b0, 32'h00F0_F0FF, 1'b0, 579, 300, 40, "R2");
    // R4 R7: E1 with slot 0 off, falling edge
    run_frames(1'b1, 32'hFFFF_FFFE, 1'b1, 512, -1, 55, "R4");
    // R4: clear-channel E1
    run_frames(1'b1, 32'hFFFF_FFFF, 1'b0, 256, -1, 30, "R4");

    // R6 R8: gapped clock, mask and frame pulse inert, idle fill while tx_valid_i low
    cfg_e1_i = 0; cfg_gapped_i = 1; cfg_loop_i = 0; loop_mode = 0;
    cfg_tx_fall_i = 0; cfg_rx_fall_i = 0; cfg_slot_en_i = '0;
    tx_lclk_i = 0; rx_lclk_i = 0; rx_tag = "R6"; tx_tag = "R8";
    do_reset();
    for (int i = 0; i < 200; i++) begin
      logic d;
      tx_valid_i = !(i >= 40 && i < 80);
      rx_next_bit(d);
      line_bit((i % 37) == 0, d, 1'b1, 1'b0);
    end
    tx_valid_i = 1;
    repeat (16) @(negedge clk_i);
    check(rx_count >= 20, "R6", "rx byte count", rx_count, 20);

    // R9: loopback, line receive inputs toggling with garbage
    cfg_e1_i = 1; cfg_gapped_i = 0; cfg_loop_i = 1; loop_mode = 1;
    cfg_slot_en_i = 32'h0000_0F0F; rx_tag = "R9";
    do_reset();
    for (int i = 0; i < 750; i++) begin
      rx_lclk_i = ~rx_lclk_i;
      rx_data_i = i[1] ^ i[3];
      rx_fp_i = (i % 11) == 0;
      repeat (8) @(negedge clk_i);
    end
    check(rx_count >= 16, "R9", "loopback rx byte count", rx_count, 16);

    summary();
    $finish;
  end
endmodule